// File: doc/BRIEF.md
# Coded Reference Divider With Monitor Output

This block divides a reference clock down to a phase-comparison rate. Software picks the ratio with a 5-bit code instead of a binary count. The two high code bits pick a base of 2, 5, 6 or 7. The three low bits pick a power of two that scales that base. Three codes have no meaning. The block flags them and keeps the ratio it already had. The divided clock is a 50% square wave for even ratios and a one-cycle pulse for odd ratios.

A monitor pin can carry the undivided reference clock, carry the divided clock, or be released (high impedance). The ratio code and the two monitor control bits are captured together on a single-cycle write strobe. A new ratio does not cut a period short: it waits for the current comparison period to end. The monitor controls reset to "enabled, divided clock", and the ratio resets to 2.

Top module: `refdiv_top`

## Requirements
- R1: With code bits [4:3] = 00, low bits [2:0] = k (0..7) select a ratio of 2^(k+1), from 2 up to 256.
- R2: With code bits [4:3] = 01, low bits k = 1..7 select a ratio of 5·2^(k-1), from 5 up to 320.
- R3: With code bits [4:3] = 10, low bits k = 1..7 select a ratio of 6·2^(k-1), from 6 up to 384.
- R4: With code bits [4:3] = 11, low bits k = 1..7 select a ratio of 7·2^(k-1), from 7 up to 448.
- R5: A write of code 01000, 10000 or 11000 sets `code_bad` in the cycle after the strobe and leaves the ratio unchanged. A later write of a legal code clears `code_bad`.
- R6: A written ratio takes effect at the first comparison-period boundary after the write edge. A write on the boundary edge itself takes effect one period later.
- R7: For an even ratio N, `comp_out` goes high at the start of each period, stays high for N/2 cycles and stays low for N/2 cycles.
- R8: For an odd ratio N, `comp_out` is high for exactly one cycle at the start of each N-cycle period.
- R9: With the captured enable at 0, `mon_oe` is 0 and `mon_out` is held at 0.
- R10: With enable 1 and select 0 captured, `mon_oe` is 1 and `mon_out` follows the reference clock level.
- R11: With enable 1 and select 1 captured, `mon_oe` is 1 and `mon_out` equals `comp_out`.
- R12: After reset, enable and select are both 1, the ratio is 2 and `code_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle strobe that captures code, enable and select |
| ratio_code | input | 5 | Coded division ratio |
| mon_en | input | 1 | Monitor enable, captured on `cfg_wr` |
| mon_sel | input | 1 | Monitor source, 0 = reference, 1 = comparison; captured on `cfg_wr` |
| comp_out | output | 1 | Divided comparison clock or pulse |
| mon_out | output | 1 | Monitor data |
| mon_oe | output | 1 | Monitor output enable; 0 means the pin is high impedance |
| code_bad | output | 1 | Set after a write of an illegal code |

## Verification
Two things can happen on the same edge: a configuration write and the end of a comparison period. When they coincide, the ratio that loads at the boundary is the one written earlier. The newly written ratio has to wait for the boundary after that. The bench first locks onto a rising edge of `comp_out` and then counts cycles so that the strobe lands exactly on the boundary edge. It judges the result by the length of the next two periods, which must be the old ratio and then the new one. A full sweep of all 32 codes also puts every illegal write right after a legal one, so a ratio that is kept can be told apart from one that was overwritten.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
  import refdiv_pkg::*;
#(
  parameter int RATIO_W = 9
) (
  input  code_t              code,
  output logic [RATIO_W-1:0] ratio,
  output logic               illegal
);
  logic [1:0] grp;
  logic [2:0] exp_sel;
  logic [2:0] base;
  logic [2:0] shift;

  assign grp     = code[4:3];
  assign exp_sel = code[2:0];

  always_comb begin
    illegal = (grp != 2'd0) && (exp_sel == 3'd0);
    if (grp == 2'd0) begin
      base  = 3'd2;
      shift = exp_sel;
    end else begin
      base  = 3'd4 + {1'b0, grp};
      shift = exp_sel - 3'd1;
    end
    ratio = RATIO_W'(base) << shift;
  end
endmodule

// File: rtl/refdiv_cfg.sv
module refdiv_cfg
  import refdiv_pkg::*;
#(
  parameter int RATIO_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  code_t              code,
  output logic [RATIO_W-1:0] pend_n,
  output logic               code_bad
);
  logic [RATIO_W-1:0] dec_ratio;
  logic               dec_bad;

  refdiv_decode #(.RATIO_W(RATIO_W)) u_dec (
    .code    (code),
    .ratio   (dec_ratio),
    .illegal (dec_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_n   <= RATIO_W'(2);
      code_bad <= 1'b0;
    end else if (cfg_wr) begin
      code_bad <= dec_bad;
      if (!dec_bad) pend_n <= dec_ratio;
    end
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int RATIO_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] pend_n,
  output logic [RATIO_W-1:0] cur_n,
  output logic               cnt_zero,
  output logic               comp_q
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] nxt_cnt;
  logic [RATIO_W-1:0] nxt_n;
  logic               at_end;
  logic               nxt_comp;

  assign at_end   = (cnt == cur_n - RATIO_W'(1));
  assign cnt_zero = (cnt == '0);

  always_comb begin
    nxt_n   = at_end ? pend_n : cur_n;
    nxt_cnt = at_end ? '0 : cnt + RATIO_W'(1);
    if (nxt_n[0]) nxt_comp = (nxt_cnt == '0);
    else          nxt_comp = (nxt_cnt < (nxt_n >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_n  <= RATIO_W'(2);
      cnt    <= RATIO_W'(1);
      comp_q <= 1'b0;
    end else begin
      cur_n  <= nxt_n;
      cnt    <= nxt_cnt;
      comp_q <= nxt_comp;
    end
  end
endmodule

// File: rtl/refdiv_monsel.sv
module refdiv_monsel (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic en_in,
  input  logic sel_in,
  input  logic comp_in,
  output logic mon_out,
  output logic mon_oe
);
  logic en_q;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b1;
      sel_q <= 1'b1;
    end else if (cfg_wr) begin
      en_q  <= en_in;
      sel_q <= sel_in;
    end
  end

  assign mon_oe  = en_q;
  assign mon_out = en_q & (sel_q ? comp_in : clk);
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int RATIO_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              mon_en,
  input  logic              mon_sel,
  output logic              comp_out,
  output logic              mon_out,
  output logic              mon_oe,
  output logic              code_bad
);
  logic [RATIO_W-1:0] pend_n;
  logic [RATIO_W-1:0] cur_n;
  logic               cnt_zero;

  refdiv_cfg #(.RATIO_W(RATIO_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .code     (ratio_code),
    .pend_n   (pend_n),
    .code_bad (code_bad)
  );

  refdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .pend_n   (pend_n),
    .cur_n    (cur_n),
    .cnt_zero (cnt_zero),
    .comp_q   (comp_out)
  );

  refdiv_monsel u_mon (
    .clk     (clk),
    .rst     (rst),
    .cfg_wr  (cfg_wr),
    .en_in   (mon_en),
    .sel_in  (mon_sel),
    .comp_in (comp_out),
    .mon_out (mon_out),
    .mon_oe  (mon_oe)
  );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int RATIO_W = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_wr,
  input logic [4:0]         ratio_code,
  input logic               mon_en,
  input logic               comp_out,
  input logic               mon_out,
  input logic               mon_oe,
  input logic               code_bad,
  input logic [RATIO_W-1:0] pend_n,
  input logic [RATIO_W-1:0] cur_n,
  input logic               cnt_zero
);
  logic bad_wr;
  assign bad_wr = cfg_wr && (ratio_code[2:0] == 3'd0) && (ratio_code[4:3] != 2'd0);

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> code_bad);

  assert_ratio_kept_R5: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> $stable(pend_n));

  assert_change_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_n) |-> cnt_zero);

  assert_odd_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (comp_out && cur_n[0]) |=> !comp_out);

  assert_off_quiet_R9: assert property (@(negedge clk) disable iff (rst)
    !mon_oe |-> !mon_out);

  assert_enable_capture_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (mon_oe == $past(mon_en)));

  assert_reset_state_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mon_oe && !code_bad));
endmodule

bind refdiv_top refdiv_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .ratio_code (ratio_code),
  .mon_en     (mon_en),
  .comp_out   (comp_out),
  .mon_out    (mon_out),
  .mon_oe     (mon_oe),
  .code_bad   (code_bad),
  .pend_n     (pend_n),
  .cur_n      (cur_n),
  .cnt_zero   (cnt_zero)
);

// File: tb/refdiv_top_tb.sv
module refdiv_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [4:0] ratio_code = 5'd0;
  logic       mon_en = 1'b1;
  logic       mon_sel = 1'b1;
  logic       comp_out, mon_out, mon_oe, code_bad;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refdiv_top u_dut (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .ratio_code (ratio_code),
    .mon_en     (mon_en),
    .mon_sel    (mon_sel),
    .comp_out   (comp_out),
    .mon_out    (mon_out),
    .mon_oe     (mon_oe),
    .code_bad   (code_bad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int c);
    int grp = c / 8;
    int k = c % 8;
    if (grp == 0) return 2 ** (k + 1);
    return (4 + grp) * (2 ** (k - 1));
  endfunction

  function automatic bit is_bad(input int c);
    return (c % 8 == 0) && (c / 8 != 0);
  endfunction

  task automatic wr(input int c, input bit en, input bit sel);
    @(negedge clk);
    cfg_wr = 1'b1; ratio_code = 5'(c); mon_en = en; mon_sel = sel;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Counts negedges until the next rising edge of comp_out; hi counts high samples.
  task automatic next_rise(output int cyc, output int hi);
    bit prev = comp_out;
    hi = comp_out ? 1 : 0;
    cyc = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cyc++;
      if (comp_out && !prev) return;
      if (comp_out) hi++;
      prev = comp_out;
    end
    chk(1'b0, "timeout waiting for comp_out rise", cyc, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int per, hi, last_n, e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk(mon_oe == 1'b1, "R12 mon_oe after reset", mon_oe, 1);
    chk(code_bad == 1'b0, "R12 code_bad after reset", code_bad, 0);
    next_rise(per, hi);
    next_rise(per, hi);
    chk(per == 2, "R12 reset ratio period", per, 2);
    chk(mon_out == comp_out, "R12 monitor shows comparison after reset", mon_out, comp_out);

    // Sweep all codes: R1-style groups, illegal handling
    last_n = 2;
    for (int c = 0; c < 32; c++) begin
      wr(c, 1'b1, 1'b1);
      chk(code_bad == is_bad(c), $sformatf("R5 flag for code %0d", c), code_bad, is_bad(c));
      e = is_bad(c) ? last_n : exp_ratio(c);
      next_rise(per, hi);
      next_rise(per, hi);
      next_rise(per, hi);
      case (c / 8)
        0: chk(per == e, $sformatf("R1 period code %0d", c), per, e);
        1: chk(per == e, $sformatf("R2 period code %0d", c), per, e);
        2: chk(per == e, $sformatf("R3 period code %0d", c), per, e);
        default: chk(per == e, $sformatf("R4 period code %0d", c), per, e);
      endcase
      if (is_bad(c)) chk(per == last_n, $sformatf("R5 ratio kept code %0d", c), per, last_n);
      if (e % 2 == 0) chk(hi == e / 2, $sformatf("R7 high time ratio %0d", e), hi, e / 2);
      else            chk(hi == 1, $sformatf("R8 pulse width ratio %0d", e), hi, 1);
      last_n = e;
    end

    // R6: write lands on the boundary edge
    wr(1, 1'b1, 1'b1);
    next_rise(per, hi);
    next_rise(per, hi);
    next_rise(per, hi);
    repeat (3) @(negedge clk);
    cfg_wr = 1'b1; ratio_code = 5'b10001;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(comp_out == 1'b1, "R6 boundary aligned", comp_out, 1);
    next_rise(per, hi);
    chk(per == 4, "R6 old ratio holds one more period", per, 4);
    next_rise(per, hi);
    chk(per == 6, "R6 new ratio after next boundary", per, 6);

    // R10 reference on monitor
    wr(1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(mon_out == 1'b1 && mon_oe, "R10 monitor high with clk high", mon_out, 1);
      @(negedge clk);
      chk(mon_out == 1'b0 && mon_oe, "R10 monitor low with clk low", mon_out, 0);
    end

    // R11 comparison on monitor
    wr(1, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(mon_out == comp_out && mon_oe, "R11 monitor equals comp_out", mon_out, comp_out);
    end

    // R9 disabled
    wr(1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(mon_oe == 1'b0 && mon_out == 1'b0, "R9 disabled high phase", mon_out, 0);
      @(negedge clk);
      chk(mon_oe == 1'b0 && mon_out == 1'b0, "R9 disabled low phase", mon_out, 0);
    end
    wr(1, 1'b0, 1'b1);
    repeat (6) begin
      @(negedge clk);
      chk(mon_oe == 1'b0 && mon_out == 1'b0, "R9 disabled with select 1", mon_out, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule